// File: doc/BRIEF.md
# ATA Programmed-I/O Register Cycle Engine

This block is the host side of a parallel ATA register access in programmed-I/O mode. A local requester presents one request: a read/write flag, a flag that picks the command or the control register block, a 3-bit register address and 16 bits of write data. The engine runs the bus cycle and reports completion with a one-cycle done pulse. On a read, the captured data comes back with that pulse.

The cycle has four phases. In the setup phase the address and one chip select are driven. In the strobe phase the read or write strobe is low. The hold phase lasts one cycle and keeps address and select after the strobe. The recovery phase is a quiet gap before the next access can start. The lengths of setup, strobe and recovery are counted in clock cycles and come from configuration inputs. A device-driven ready line stretches the strobe. It is brought into the clock domain through a two-flop synchronizer. The data bus is split into an input, an output and an output enable. The DMA acknowledge is held inactive.

Top module: `ata_pio_engine`

## Requirements
- R1: While a cycle is in its setup, strobe or hold phase, exactly one chip select is low. `dev_cs_ctl_n` is low when `req_ctrl` was 1, and `dev_cs_cmd_n` is low when it was 0. `dev_addr` equals the requested address. Outside these phases both selects are high.
- R2: Address and chip select are driven for max(`cfg_setup`,1) cycles before the strobe goes low.
- R3: With ready high, the strobe stays low for exactly max(`cfg_strobe`,1) cycles. `dev_rd_n` is the strobe for reads (`req_write`=0) and `dev_wr_n` is the strobe for writes (`req_write`=1). The two strobes are never low together.
- R4: While the synchronized ready is low, the strobe stays low past its minimum width. It goes high on the third rising edge after `dev_ready` rises.
- R5: On a read, `rdata` holds the value of `dev_data_i` sampled at the clock edge where `dev_rd_n` goes high.
- R6: On a write, `dev_data_oe` is high and `dev_data_o` equals the write data from setup through hold. On a read, `dev_data_oe` stays low.
- R7: Address and chip select stay asserted for exactly one cycle after the strobe goes high. `done` is high in that cycle only.
- R8: After the done cycle, `busy` stays high for exactly `cfg_recov` cycles and then falls.
- R9: A request is accepted only while `busy` is low. A request made while busy does not change the running cycle and does not start another one.
- R10: `dev_dack_n` is always high.
- R11: During reset, and in the first cycle after it, `busy` and `done` are low and all strobes and selects are high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request strobe, taken when idle |
| req_write | input | 1 | 1 = write, 0 = read |
| req_ctrl | input | 1 | 1 = control block, 0 = command block |
| req_addr | input | 3 | Register address within the block |
| req_wdata | input | 16 | Write data |
| cfg_setup | input | 6 | Setup length in cycles (0 acts as 1) |
| cfg_strobe | input | 6 | Minimum strobe width in cycles (0 acts as 1) |
| cfg_recov | input | 6 | Recovery length in cycles |
| busy | output | 1 | A cycle is in progress |
| done | output | 1 | One-cycle completion pulse |
| rdata | output | 16 | Captured read data |
| dev_addr | output | 3 | Device register address |
| dev_cs_cmd_n | output | 1 | Command block select, active low |
| dev_cs_ctl_n | output | 1 | Control block select, active low |
| dev_rd_n | output | 1 | Read strobe, active low |
| dev_wr_n | output | 1 | Write strobe, active low |
| dev_dack_n | output | 1 | DMA acknowledge, held high |
| dev_ready | input | 1 | Device ready, asynchronous |
| dev_data_i | input | 16 | Data bus input |
| dev_data_o | output | 16 | Data bus output |
| dev_data_oe | output | 1 | Data bus output enable |

## Verification
The bench runs reads and writes to both register blocks with different setup, strobe and recovery settings. This separates the phase lengths from each other and confirms that zero settings are treated as one cycle. During the strobe, the bench changes the read data bus on every cycle, so the captured value shows the exact edge at which it was taken. In one read, ready is held low well past the minimum width, which checks the stretch and the synchronizer latency. In one write, a conflicting request arrives in the middle of the strobe, and the bench checks that the running cycle's address and select do not change and that no second cycle follows.

// File: rtl/ata_pio_pkg.sv
package ata_pio_pkg;
  typedef enum logic [2:0] {
    PIO_IDLE   = 3'd0,
    PIO_SETUP  = 3'd1,
    PIO_STROBE = 3'd2,
    PIO_HOLD   = 3'd3,
    PIO_RECOV  = 3'd4
  } pio_state_e;
endpackage

// File: rtl/ata_rdy_sync.sv
module ata_rdy_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d,
  output logic q
);
  logic [STAGES-1:0] sh, sh_nxt;

  always_comb sh_nxt = {sh[STAGES-2:0], d};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sh <= '0;
    else        sh <= sh_nxt;
  end

  assign q = sh[STAGES-1];
endmodule

// File: rtl/ata_phase_cnt.sv
module ata_phase_cnt #(
  parameter int W = 6
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load,
  input  logic [W-1:0] load_val,
  output logic         zero
);
  logic [W-1:0] cnt, cnt_nxt;

  // A loaded length of N gives N cycles of the phase; 0 acts as 1.
  always_comb begin
    cnt_nxt = cnt;
    if (load)          cnt_nxt = (load_val == '0) ? '0 : load_val - W'(1);
    else if (cnt != '0) cnt_nxt = cnt - W'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt <= '0;
    else        cnt <= cnt_nxt;
  end

  assign zero = (cnt == '0);
endmodule

// File: rtl/ata_pio_engine.sv
module ata_pio_engine
  import ata_pio_pkg::*;
#(
  parameter int CNT_W   = 6,
  parameter int ADDR_W  = 3,
  parameter int DATA_W  = 16,
  parameter int SYNC_ST = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  input  logic              req_write,
  input  logic              req_ctrl,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [DATA_W-1:0] req_wdata,
  input  logic [CNT_W-1:0]  cfg_setup,
  input  logic [CNT_W-1:0]  cfg_strobe,
  input  logic [CNT_W-1:0]  cfg_recov,
  output logic              busy,
  output logic              done,
  output logic [DATA_W-1:0] rdata,
  output logic [ADDR_W-1:0] dev_addr,
  output logic              dev_cs_cmd_n,
  output logic              dev_cs_ctl_n,
  output logic              dev_rd_n,
  output logic              dev_wr_n,
  output logic              dev_dack_n,
  input  logic              dev_ready,
  input  logic [DATA_W-1:0] dev_data_i,
  output logic [DATA_W-1:0] dev_data_o,
  output logic              dev_data_oe
);
  pio_state_e        state, state_nxt;
  logic              rdy_s;
  logic              cnt_load, cnt_zero;
  logic [CNT_W-1:0]  cnt_val;
  logic              accept, cap_en;
  logic              wr_q, ctl_q;
  logic [ADDR_W-1:0] addr_q;
  logic [DATA_W-1:0] wdata_q, rdata_q;
  logic              in_cycle;

  ata_rdy_sync #(.STAGES(SYNC_ST)) u_sync (
    .clk(clk), .rst_n(rst_n), .d(dev_ready), .q(rdy_s)
  );

  ata_phase_cnt #(.W(CNT_W)) u_cnt (
    .clk(clk), .rst_n(rst_n), .load(cnt_load), .load_val(cnt_val), .zero(cnt_zero)
  );

  // Next-state logic
  always_comb begin
    state_nxt = state;
    cnt_load  = 1'b0;
    cnt_val   = '0;
    accept    = 1'b0;
    cap_en    = 1'b0;
    case (state)
      PIO_IDLE: if (req_valid) begin
        accept    = 1'b1;
        state_nxt = PIO_SETUP;
        cnt_load  = 1'b1;
        cnt_val   = cfg_setup;
      end
      PIO_SETUP: if (cnt_zero) begin
        state_nxt = PIO_STROBE;
        cnt_load  = 1'b1;
        cnt_val   = cfg_strobe;
      end
      PIO_STROBE: if (cnt_zero && rdy_s) begin
        state_nxt = PIO_HOLD;
        cap_en    = ~wr_q;
      end
      PIO_HOLD: begin
        if (cfg_recov == '0) state_nxt = PIO_IDLE;
        else begin
          state_nxt = PIO_RECOV;
          cnt_load  = 1'b1;
          cnt_val   = cfg_recov;
        end
      end
      PIO_RECOV: if (cnt_zero) state_nxt = PIO_IDLE;
      default: state_nxt = PIO_IDLE;
    endcase
  end

  // Registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state <= PIO_IDLE;
    else        state <= state_nxt;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_q    <= 1'b0;
      ctl_q   <= 1'b0;
      addr_q  <= '0;
      wdata_q <= '0;
    end else if (accept) begin
      wr_q    <= req_write;
      ctl_q   <= req_ctrl;
      addr_q  <= req_addr;
      wdata_q <= req_wdata;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      rdata_q <= '0;
    else if (cap_en) rdata_q <= dev_data_i;
  end

  // Output decode from registered state
  assign in_cycle     = (state == PIO_SETUP) || (state == PIO_STROBE) || (state == PIO_HOLD);
  assign dev_cs_cmd_n = ~(in_cycle & ~ctl_q);
  assign dev_cs_ctl_n = ~(in_cycle &  ctl_q);
  assign dev_addr     = in_cycle ? addr_q : '0;
  assign dev_rd_n     = ~((state == PIO_STROBE) & ~wr_q);
  assign dev_wr_n     = ~((state == PIO_STROBE) &  wr_q);
  assign dev_data_oe  = in_cycle & wr_q;
  assign dev_data_o   = wdata_q;
  assign dev_dack_n   = 1'b1;
  assign done         = (state == PIO_HOLD);
  assign busy         = (state != PIO_IDLE);
  assign rdata        = rdata_q;
endmodule

// File: rtl/ata_pio_chk.sv
module ata_pio_chk (
  input logic clk,
  input logic rst_n,
  input logic busy,
  input logic done,
  input logic dev_cs_cmd_n,
  input logic dev_cs_ctl_n,
  input logic dev_rd_n,
  input logic dev_wr_n,
  input logic dev_dack_n,
  input logic dev_data_oe,
  input logic rdy_s
);
  logic strobe_lo, cs_any;
  assign strobe_lo = ~dev_rd_n | ~dev_wr_n;
  assign cs_any    = ~dev_cs_cmd_n | ~dev_cs_ctl_n;

  assert_one_cs_R1: assert property (@(posedge clk) disable iff (!rst_n)
    !(~dev_cs_cmd_n & ~dev_cs_ctl_n));

  assert_strobe_has_cs_R1: assert property (@(posedge clk) disable iff (!rst_n)
    strobe_lo |-> cs_any);

  assert_strobe_excl_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !(~dev_rd_n & ~dev_wr_n));

  assert_stretch_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (strobe_lo && !rdy_s) |=> strobe_lo);

  assert_read_no_drive_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !dev_rd_n |-> !dev_data_oe);

  assert_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(strobe_lo) |-> (cs_any && done));

  assert_done_pulse_R7: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  assert_idle_quiet_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> (!cs_any && !strobe_lo));

  assert_dack_R10: assert property (@(posedge clk) disable iff (!rst_n)
    dev_dack_n);
endmodule

bind ata_pio_engine ata_pio_chk u_chk (
  .clk(clk), .rst_n(rst_n), .busy(busy), .done(done),
  .dev_cs_cmd_n(dev_cs_cmd_n), .dev_cs_ctl_n(dev_cs_ctl_n),
  .dev_rd_n(dev_rd_n), .dev_wr_n(dev_wr_n), .dev_dack_n(dev_dack_n),
  .dev_data_oe(dev_data_oe), .rdy_s(rdy_s)
);

// File: tb/sim_ata_pio_engine.sv
module sim_ata_pio_engine;
  logic        clk, rst_n;
  logic        req_valid, req_write, req_ctrl;
  logic [2:0]  req_addr;
  logic [15:0] req_wdata;
  logic [5:0]  cfg_setup, cfg_strobe, cfg_recov;
  logic        busy, done;
  logic [15:0] rdata;
  logic [2:0]  dev_addr;
  logic        dev_cs_cmd_n, dev_cs_ctl_n, dev_rd_n, dev_wr_n, dev_dack_n;
  logic        dev_ready;
  logic [15:0] dev_data_i, dev_data_o;
  logic        dev_data_oe;

  int checks = 0;
  int failures = 0;
  bit finished = 0;
  localparam logic [15:0] RD_BASE = 16'hA000;

  ata_pio_engine u0 (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
    .req_ctrl(req_ctrl), .req_addr(req_addr), .req_wdata(req_wdata),
    .cfg_setup(cfg_setup), .cfg_strobe(cfg_strobe), .cfg_recov(cfg_recov),
    .busy(busy), .done(done), .rdata(rdata), .dev_addr(dev_addr),
    .dev_cs_cmd_n(dev_cs_cmd_n), .dev_cs_ctl_n(dev_cs_ctl_n),
    .dev_rd_n(dev_rd_n), .dev_wr_n(dev_wr_n), .dev_dack_n(dev_dack_n),
    .dev_ready(dev_ready), .dev_data_i(dev_data_i), .dev_data_o(dev_data_o),
    .dev_data_oe(dev_data_oe)
  );

  initial clk = 1'b0;
  always #2 clk = ~clk;

  task automatic chk(input string req, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic summary();
    if (!finished) begin
      finished = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    end
  endtask

  function automatic int quiet_bus();
    return int'(dev_cs_cmd_n & dev_cs_ctl_n & dev_rd_n & dev_wr_n & ~busy & ~done);
  endfunction

  // R11: outputs in and right after reset
  task automatic t_reset();
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    chk("R11", "quiet bus in reset", quiet_bus(), 1);
    chk("R11", "no drive in reset", int'(dev_data_oe), 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R11", "quiet bus after reset", quiet_bus(), 1);
    chk("R10", "dack high after reset", int'(dev_dack_n), 1);
    repeat (3) @(negedge clk);
  endtask

  // One full access, measured phase by phase at falling edges
  task automatic t_access(input string nm, input bit wr, input bit ctl, input logic [2:0] a,
                          input logic [15:0] wd, input int s, input int w, input int r,
                          input bit stretch, input bit inject);
    int es, ew, m, exp_w;
    int n_setup, n_strobe, n_hold, n_recov, n_done;
    int bad_sel, bad_oe, bad_kind, bad_dack;
    int got_rd;
    bit seen_stb, fin, injected, inj_clear;
    logic stb, csl;
    es = (s < 1) ? 1 : s;
    ew = (w < 1) ? 1 : w;
    m = ew + 4;
    exp_w = stretch ? m + 2 : ew;
    n_setup = 0; n_strobe = 0; n_hold = 0; n_recov = 0; n_done = 0;
    bad_sel = 0; bad_oe = 0; bad_kind = 0; bad_dack = 0; got_rd = -1;
    seen_stb = 0; fin = 0; injected = 0; inj_clear = 0;
    $display("scenario %s", nm);
    if (stretch) begin
      dev_ready = 1'b0;
      repeat (4) @(negedge clk);
    end
    cfg_setup = 6'(s); cfg_strobe = 6'(w); cfg_recov = 6'(r);
    req_write = wr; req_ctrl = ctl; req_addr = a; req_wdata = wd; req_valid = 1'b1;
    @(negedge clk);
    req_valid = 1'b0;
    for (int i = 0; i < 400 && !fin; i++) begin
      if (inj_clear) begin
        req_valid = 1'b0; req_write = wr; req_ctrl = ctl; req_addr = a; req_wdata = wd;
        inj_clear = 0;
      end
      stb = ~dev_rd_n | ~dev_wr_n;
      csl = ~dev_cs_cmd_n | ~dev_cs_ctl_n;
      if (!dev_dack_n) bad_dack++;
      if (csl && (dev_addr !== a || dev_cs_ctl_n !== ~ctl || dev_cs_cmd_n !== ctl)) bad_sel++;
      if (dev_data_oe !== (wr & csl)) bad_oe++;
      if (dev_data_oe && dev_data_o !== wd) bad_oe++;
      if (done) begin
        n_done++;
        got_rd = int'(rdata);
      end
      if (stb) begin
        seen_stb = 1;
        n_strobe++;
        if ((wr && dev_wr_n) || (!wr && dev_rd_n)) bad_kind++;
        if (!dev_rd_n) dev_data_i = RD_BASE + 16'(n_strobe);
        if (stretch && n_strobe == m) dev_ready = 1'b1;
        if (inject && !injected) begin
          req_valid = 1'b1; req_write = ~wr; req_ctrl = ~ctl; req_addr = ~a; req_wdata = ~wd;
          injected = 1; inj_clear = 1;
        end
      end else if (!seen_stb) begin
        if (csl) n_setup++;
      end else begin
        if (csl) n_hold++;
        else if (busy) n_recov++;
        if (!busy) fin = 1;
      end
      if (!fin) @(negedge clk);
    end
    dev_ready = 1'b1;
    req_valid = 1'b0;
    chk("R8", {nm, " access finished"}, int'(fin), 1);
    chk("R1", {nm, " select/address"}, bad_sel, 0);
    chk("R2", {nm, " setup cycles"}, n_setup, es);
    chk(stretch ? "R4" : "R3", {nm, " strobe cycles"}, n_strobe, exp_w);
    chk("R3", {nm, " strobe kind"}, bad_kind, 0);
    chk("R6", {nm, " data drive"}, bad_oe, 0);
    chk("R7", {nm, " hold cycles"}, n_hold, 1);
    chk("R7", {nm, " done pulses"}, n_done, 1);
    chk("R8", {nm, " recovery cycles"}, n_recov, r);
    chk("R10", {nm, " dack"}, bad_dack, 0);
    if (!wr) chk("R5", {nm, " read data"}, got_rd, int'(RD_BASE) + exp_w);
    // R9: nothing further starts
    repeat (4) begin
      @(negedge clk);
      chk("R9", {nm, " idle afterwards"}, quiet_bus(), 1);
    end
  endtask

  initial begin
    req_valid = 1'b0; req_write = 1'b0; req_ctrl = 1'b0; req_addr = '0; req_wdata = '0;
    cfg_setup = '0; cfg_strobe = '0; cfg_recov = '0;
    dev_ready = 1'b1; dev_data_i = '0;
    t_reset();
    t_access("read_cmd", 1'b0, 1'b0, 3'd5, 16'h0000, 2, 3, 2, 1'b0, 1'b0);
    t_access("write_ctl", 1'b1, 1'b1, 3'd6, 16'h1234, 1, 4, 0, 1'b0, 1'b0);
    t_access("zero_cfg", 1'b0, 1'b1, 3'd2, 16'h0000, 0, 0, 0, 1'b0, 1'b0);
    t_access("read_stretch", 1'b0, 1'b0, 3'd7, 16'h0000, 3, 2, 1, 1'b1, 1'b0);
    t_access("write_inject", 1'b1, 1'b0, 3'd1, 16'hBEEF, 2, 5, 3, 1'b0, 1'b1);
    summary();
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    failures++;
    $display("FAIL watchdog: actual=%0d expected=%0d", 1, 0);
    summary();
    $finish;
  end
endmodule